// File: doc/BRIEF.md
# Flash Controller Command Sequencer

This block is the register front end of an embedded flash controller. A host writes single-cycle register accesses on a 32-bit bus. It sets a target byte address and up to four data words, then writes a control word that carries an unlock key, an erase qualifier and a start bit. The block qualifies the command before it lets it run. The key must be open, the qualifier must match the command type, the address must be legal and aligned, and the page must not be write-protected. A refused command leaves the flash untouched and raises a sticky fail flag. An accepted command holds a pending flag for a fixed number of cycles and then acts on the flash array. The array is modelled inside the block.

The supported commands are page erase, mass erase, and a 32-bit or 128-bit program. Programming can only clear bits, so the new word is the AND of the old word and the data. Erased flash reads as all ones. A separate read port gives direct access to any array word, so the host can inspect the flash contents without going through the register bus.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the control word, the status word, the address, divider, data and protect registers all read 0. Every array word reads 0xFFFFFFFF.
- R2: The control unlock key is bits [31:28]. A start bit written while the key is not 0x2 is refused. A refused command sets the fail flag, starts no pending period and leaves the array unchanged.
- R3: The control erase qualifier is bits [15:8]. A page erase needs 0x55, a mass erase needs 0xAA and a program needs 0x00. Any other value refuses the command.
- R4: Control bit 2 starts a page erase, bit 1 starts a mass erase and bit 0 starts a program. A write with more than one of these bits set is refused.
- R5: The pending flag is control bit 24. It reads 1 for exactly WR_CYC, PE_CYC or ME_CYC cycles after a program, page erase or mass erase is accepted. When it drops, the start bits and the qualifier read 0, while the key and mode bits keep their values.
- R6: While the pending flag is 1, a control write with a start bit is refused and sets the fail flag. Writes to the control, address, data and protect registers are ignored during that time.
- R7: Control bit 4 selects a 32-bit program of data word 0, which needs address bits [1:0] = 0. Control bit 27 selects a 128-bit program in which data word k goes to address+4k, which needs address bits [3:0] = 0. Setting both bits, setting neither, or using a misaligned address refuses the command. A program stores the AND of the old word and the data.
- R8: A page erase sets every word of the page that holds the address register to 0xFFFFFFFF. An address at or beyond the array size refuses the command.
- R9: A mass erase sets every unprotected page to all ones and leaves protected pages unchanged. It is refused when every page is protected.
- R10: Page p is protected when bit p mod 32 of the protect word at 0x300 + 4*(p div 32) is 1. A page erase or program aimed at a protected page is refused.
- R11: The fail flag is status bit 1. A status write stores bit 1 of the written value, so writing 0 clears the flag.
- R12: The register offsets are: address 0x000, divider 0x004 (stored and read back), control 0x008, status 0x024, and data word k at 0x030 + 4k. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| arr_addr | input | $clog2(PAGES*PAGE_WORDS) | Word index for the direct array read port |
| arr_rdata | output | 32 | Array word at arr_addr |

## Verification
The bench builds the block with 40 pages of 4 words and pending lengths of 3, 5 and 9 cycles. Forty pages need a second protect word, so the page-to-bit mapping across the word boundary can be exercised. Four-word pages keep both the array and the erase loops small. The short pending windows let the bench count each pending period cycle by cycle and hit the pending window with a second command. A full-array comparison runs continuously against the behavioural model.

// File: rtl/fcs_pkg.sv
// Package: shared command type and register offsets of the flash command sequencer.
// Assumes a 12-bit register offset bus.
package fcs_pkg;
    typedef enum logic [1:0] {OP_NONE, OP_PAGE, OP_MASS, OP_PROG} fcs_op_e;

    localparam logic [3:0]  KEY_OPEN   = 4'h2;
    localparam logic [7:0]  QUAL_PAGE  = 8'h55;
    localparam logic [7:0]  QUAL_MASS  = 8'hAA;

    localparam logic [11:0] OFF_ADDR   = 12'h000;
    localparam logic [11:0] OFF_DIV    = 12'h004;
    localparam logic [11:0] OFF_CTRL   = 12'h008;
    localparam logic [11:0] OFF_STAT   = 12'h024;
    localparam logic [11:0] OFF_DATA   = 12'h030;
    localparam logic [11:0] OFF_PROT   = 12'h300;
endpackage

// File: rtl/fcs_guard.sv
// Command qualifier: decides whether an incoming control word may start a command.
// Purely combinational. Assumes PAGE_WORDS is a power of two and PAGES >= 2.
module fcs_guard
    import fcs_pkg::*;
#(
    parameter int PAGES      = 8,
    parameter int PAGE_WORDS = 16,
    localparam int PW        = $clog2(PAGES),
    localparam int PB_SH     = $clog2(PAGE_WORDS) + 2,
    localparam int SIZE      = PAGES * PAGE_WORDS * 4
) (
    input  logic [2:0]       start,
    input  logic [3:0]       key,
    input  logic [7:0]       qual,
    input  logic             m32,
    input  logic             m128,
    input  logic [31:0]      addr,
    input  logic [PAGES-1:0] prot,
    output logic             ok,
    output fcs_op_e          op
);
    logic [31:0] page_idx;
    logic        in_range;
    logic        page_locked;
    logic        aligned;

    // Derive the page, range and alignment facts for the current address.
    always_comb begin
        page_idx    = addr >> PB_SH;
        in_range    = addr < 32'(SIZE);
        page_locked = in_range ? prot[page_idx[PW-1:0]] : 1'b1;
        aligned     = m128 ? (addr[3:0] == 4'd0) : (addr[1:0] == 2'd0);
    end

    // Match the start bits to one command and apply its own qualification rules.
    always_comb begin
        ok = 1'b0;
        op = OP_NONE;
        case (start)
            3'b100: begin
                op = OP_PAGE;
                ok = (key == KEY_OPEN) && (qual == QUAL_PAGE) && in_range && !page_locked;
            end
            3'b010: begin
                op = OP_MASS;
                ok = (key == KEY_OPEN) && (qual == QUAL_MASS) && (|(~prot));
            end
            3'b001: begin
                op = OP_PROG;
                ok = (key == KEY_OPEN) && (qual == 8'h00) && (m32 ^ m128)
                     && in_range && !page_locked && aligned;
            end
            default: begin
                ok = 1'b0;
                op = OP_NONE;
            end
        endcase
    end
endmodule

// File: rtl/fcs_timer.sv
// Pending timer: holds busy for a command-specific number of cycles and pulses done
// in the last one. Assumes load only arrives while idle and that every length is >= 1.
module fcs_timer
    import fcs_pkg::*;
#(
    parameter int WR_CYC = 4,
    parameter int PE_CYC = 16,
    parameter int ME_CYC = 40,
    localparam int MAXC  = (ME_CYC > PE_CYC) ? ((ME_CYC > WR_CYC) ? ME_CYC : WR_CYC)
                                             : ((PE_CYC > WR_CYC) ? PE_CYC : WR_CYC),
    localparam int CW    = $clog2(MAXC + 1)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  fcs_op_e op_in,
    output logic    busy,
    output logic    done,
    output fcs_op_e op
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] len;

    // Select the pending length of the command being loaded.
    always_comb begin
        case (op_in)
            OP_PAGE: len = CW'(PE_CYC);
            OP_MASS: len = CW'(ME_CYC);
            default: len = CW'(WR_CYC);
        endcase
    end

    // Count down the pending period and hold the running command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            op  <= OP_NONE;
        end else if (load) begin
            cnt <= len;
            op  <= op_in;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

    // R5
    rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) load |=> busy);
    // R5
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy);
    // R5
    end_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
endmodule

// File: rtl/fcs_array.sv
// Flash array model: words reset to all ones, erase sets ones, programming ANDs data in.
// Acts only on the done pulse. Assumes PAGE_WORDS is a power of two and >= 4.
module fcs_array
    import fcs_pkg::*;
#(
    parameter int PAGES      = 8,
    parameter int PAGE_WORDS = 16,
    localparam int WORDS     = PAGES * PAGE_WORDS,
    localparam int WW        = $clog2(WORDS),
    localparam int PWW       = $clog2(PAGE_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  fcs_op_e          op,
    input  logic             wide,
    input  logic [31:0]      addr,
    input  logic [127:0]     data,
    input  logic [PAGES-1:0] prot,
    input  logic [WW-1:0]    raddr,
    output logic [31:0]      rdata
);
    logic [31:0] mem [WORDS];
    logic [31:0] word_i;
    logic [31:0] page_i;

    assign word_i = {2'b00, addr[31:2]};
    assign page_i = addr >> (PWW + 2);

    // Apply the finished command to every word it covers.
    always_ff @(posedge clk) begin
        for (int w = 0; w < WORDS; w++) begin
            if (!rst_n) begin
                mem[w] <= '1;
            end else if (done) begin
                case (op)
                    OP_PAGE: if (page_i == (w >> PWW)) mem[w] <= '1;
                    OP_MASS: if (!prot[w >> PWW]) mem[w] <= '1;
                    OP_PROG: begin
                        if (wide) begin
                            if ((word_i >> 2) == (w >> 2)) mem[w] <= mem[w] & data[32*(w%4) +: 32];
                        end else if (word_i == w) begin
                            mem[w] <= mem[w] & data[31:0];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rdata = (32'(raddr) < 32'(WORDS)) ? mem[raddr] : 32'd0;
endmodule

// File: rtl/flash_cmd_seq.sv
// Flash command sequencer top: register file, bus decode, command start and fail flag.
// Assumes single-cycle register writes and a combinational read path.
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int PAGES      = 8,
    parameter int PAGE_WORDS = 16,
    parameter int WR_CYC     = 4,
    parameter int PE_CYC     = 16,
    parameter int ME_CYC     = 40,
    localparam int WORDS     = PAGES * PAGE_WORDS,
    localparam int WW        = $clog2(WORDS),
    localparam int NPW       = (PAGES + 31) / 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [11:0]   bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [WW-1:0] arr_addr,
    output logic [31:0]   arr_rdata
);
    logic [31:0]       addr_q, div_q;
    logic [3:0]        key_q;
    logic [7:0]        qual_q;
    logic              m32_q, m128_q, fail_q;
    logic [2:0]        start_q;
    logic [127:0]      data_q;
    logic [32*NPW-1:0] prot_q;
    logic              busy, done, ok, go, refuse, wr_ctrl;
    fcs_op_e           op_new, op_run;

    assign wr_ctrl = bus_we && (bus_addr == OFF_CTRL);
    assign go      = wr_ctrl && !busy && ok;
    assign refuse  = wr_ctrl && (bus_wdata[2:0] != 3'b000) && (busy || !ok);

    fcs_guard #(.PAGES(PAGES), .PAGE_WORDS(PAGE_WORDS)) i_guard (
        .start(bus_wdata[2:0]), .key(bus_wdata[31:28]), .qual(bus_wdata[15:8]),
        .m32(bus_wdata[4]), .m128(bus_wdata[27]), .addr(addr_q),
        .prot(prot_q[PAGES-1:0]), .ok(ok), .op(op_new)
    );

    fcs_timer #(.WR_CYC(WR_CYC), .PE_CYC(PE_CYC), .ME_CYC(ME_CYC)) i_timer (
        .clk(clk), .rst_n(rst_n), .load(go), .op_in(op_new),
        .busy(busy), .done(done), .op(op_run)
    );

    fcs_array #(.PAGES(PAGES), .PAGE_WORDS(PAGE_WORDS)) i_array (
        .clk(clk), .rst_n(rst_n), .done(done), .op(op_run), .wide(m128_q),
        .addr(addr_q), .data(data_q), .prot(prot_q[PAGES-1:0]),
        .raddr(arr_addr), .rdata(arr_rdata)
    );

    // Control register: fields load when idle; start bits and qualifier clear on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0; qual_q <= '0; m32_q <= 1'b0; m128_q <= 1'b0; start_q <= '0;
        end else if (done) begin
            start_q <= '0;
            qual_q  <= '0;
        end else if (wr_ctrl && !busy) begin
            key_q   <= bus_wdata[31:28];
            qual_q  <= bus_wdata[15:8];
            m32_q   <= bus_wdata[4];
            m128_q  <= bus_wdata[27];
            start_q <= go ? bus_wdata[2:0] : 3'b000;
        end
    end

    // Address, data and protect registers: frozen while a command is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0; data_q <= '0; prot_q <= '0;
        end else if (bus_we && !busy) begin
            if (bus_addr == OFF_ADDR) addr_q <= bus_wdata;
            for (int k = 0; k < 4; k++)
                if (bus_addr == OFF_DATA + 12'(4*k)) data_q[32*k +: 32] <= bus_wdata;
            for (int i = 0; i < NPW; i++)
                if (bus_addr == OFF_PROT + 12'(4*i)) prot_q[32*i +: 32] <= bus_wdata;
        end
    end

    // Divider register and the sticky fail flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            fail_q <= 1'b0;
        end else begin
            if (bus_we && bus_addr == OFF_DIV) div_q <= bus_wdata;
            if (refuse) fail_q <= 1'b1;
            else if (bus_we && bus_addr == OFF_STAT) fail_q <= bus_wdata[1];
        end
    end

    // Register read multiplexer.
    always_comb begin
        bus_rdata = 32'd0;
        case (bus_addr)
            OFF_ADDR: bus_rdata = addr_q;
            OFF_DIV:  bus_rdata = div_q;
            OFF_CTRL: bus_rdata = {key_q, m128_q, 2'b00, busy, 8'h00, qual_q,
                                   3'b000, m32_q, 1'b0, start_q};
            OFF_STAT: bus_rdata = {30'd0, fail_q, 1'b0};
            default:  bus_rdata = 32'd0;
        endcase
        for (int k = 0; k < 4; k++)
            if (bus_addr == OFF_DATA + 12'(4*k)) bus_rdata = data_q[32*k +: 32];
        for (int i = 0; i < NPW; i++)
            if (bus_addr == OFF_PROT + 12'(4*i)) bus_rdata = prot_q[32*i +: 32];
    end

    // R6
    refuse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) refuse |=> fail_q);
    // R5
    clear_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (start_q == 3'b000 && qual_q == 8'h00));
    // R2
    quiet_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!done) && $stable(arr_addr)) |-> $stable(arr_rdata));
    // R6
    busy_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(addr_q));
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
    localparam int PAGES = 40, PW = 4, WRC = 3, PEC = 5, MEC = 9;
    localparam int WORDS = PAGES * PW;
    localparam int AW = $clog2(WORDS);

    logic          clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0, bus_rdata, arr_rdata;
    logic [AW-1:0] arr_addr = '0;
    int            checks = 0, errors = 0, n;
    bit            hold = 0, done_run = 0;

    always #4 clk = ~clk;

    flash_cmd_seq #(.PAGES(PAGES), .PAGE_WORDS(PW), .WR_CYC(WRC), .PE_CYC(PEC), .ME_CYC(MEC))
        i_flash_cmd_seq (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arr_addr(arr_addr), .arr_rdata(arr_rdata));

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_mem [WORDS];
    logic [31:0] m_data [4];
    logic [31:0] m_prot [2];
    logic [31:0] m_addr, m_div;
    logic [3:0]  m_key;
    logic [7:0]  m_qual;
    logic        m_m32, m_m128, m_fail;
    logic [2:0]  m_start;
    int          m_cnt;
    bit          m_wasbusy;

    function automatic bit m_locked(int pg);
        return m_prot[pg / 32][pg % 32];
    endfunction

    function automatic bit m_accept(logic [31:0] w);
        bit inr = m_addr < WORDS * 4;
        bit lk = inr ? m_locked(int'(m_addr) / (PW * 4)) : 1'b1;
        bit anyfree = 0;
        for (int p = 0; p < PAGES; p++) if (!m_locked(p)) anyfree = 1;
        case (w[2:0])
            3'b100: return w[31:28] == 4'h2 && w[15:8] == 8'h55 && inr && !lk;
            3'b010: return w[31:28] == 4'h2 && w[15:8] == 8'hAA && anyfree;
            3'b001: return w[31:28] == 4'h2 && w[15:8] == 8'h00 && (w[4] ^ w[27]) && inr && !lk
                           && (w[27] ? m_addr[3:0] == 0 : m_addr[1:0] == 0);
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] m_read(logic [11:0] a);
        if (a == 12'h000) return m_addr;
        if (a == 12'h004) return m_div;
        if (a == 12'h008) return {m_key, m_m128, 2'b0, m_cnt != 0, 8'h0, m_qual, 3'b0, m_m32, 1'b0, m_start};
        if (a == 12'h024) return {30'd0, m_fail, 1'b0};
        if (a >= 12'h030 && a <= 12'h03C && a[1:0] == 0) return m_data[(a - 12'h030) / 4];
        if (a == 12'h300) return m_prot[0];
        if (a == 12'h304) return m_prot[1];
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) m_mem[i] = '1;
            for (int k = 0; k < 4; k++) m_data[k] = 0;
            m_prot[0] = 0; m_prot[1] = 0; m_addr = 0; m_div = 0; m_key = 0; m_qual = 0;
            m_m32 = 0; m_m128 = 0; m_fail = 0; m_start = 0; m_cnt = 0;
        end else begin
            m_wasbusy = m_cnt != 0;
            if (m_cnt == 1) begin
                if (m_start == 3'b100)
                    for (int i = 0; i < WORDS; i++) begin
                        if (i / PW == int'(m_addr) / (PW * 4)) m_mem[i] = '1;
                    end
                if (m_start == 3'b010)
                    for (int i = 0; i < WORDS; i++) begin
                        if (!m_locked(i / PW)) m_mem[i] = '1;
                    end
                if (m_start == 3'b001) begin
                    if (m_m128) for (int k = 0; k < 4; k++) m_mem[m_addr / 4 + k] &= m_data[k];
                    else m_mem[m_addr / 4] &= m_data[0];
                end
                m_start = 0; m_qual = 0;
            end
            if (m_cnt != 0) m_cnt--;
            if (bus_we) begin
                if (bus_addr == 12'h004) m_div = bus_wdata;
                else if (bus_addr == 12'h024) m_fail = bus_wdata[1];
                else if (bus_addr == 12'h008) begin
                    if (m_wasbusy) begin
                        if (bus_wdata[2:0] != 0) m_fail = 1;
                    end else begin
                        m_key = bus_wdata[31:28]; m_qual = bus_wdata[15:8];
                        m_m32 = bus_wdata[4]; m_m128 = bus_wdata[27]; m_start = 0;
                        if (bus_wdata[2:0] != 0) begin
                            if (m_accept(bus_wdata)) begin
                                m_start = bus_wdata[2:0];
                                m_cnt = bus_wdata[2] ? PEC : bus_wdata[1] ? MEC : WRC;
                            end else m_fail = 1;
                        end
                    end
                end else if (!m_wasbusy) begin
                    if (bus_addr == 12'h000) m_addr = bus_wdata;
                    if (bus_addr >= 12'h030 && bus_addr <= 12'h03C) m_data[(bus_addr - 12'h030) / 4] = bus_wdata;
                    if (bus_addr == 12'h300) m_prot[0] = bus_wdata;
                    if (bus_addr == 12'h304) m_prot[1] = bus_wdata;
                end
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Whole-array comparison against the model, one word per clock.
    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            #1 chk("R7 R8 R9 array word", arr_rdata, m_mem[arr_addr]);
            if (!hold) arr_addr <= (32'(arr_addr) == WORDS - 1) ? '0 : arr_addr + 1'b1;
        end
    end

    task automatic bw(logic [11:0] a, logic [31:0] d);
        @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 0;
    endtask

    task automatic rd(string req, logic [11:0] a);
        bus_addr = a; #2;
        chk(req, bus_rdata, m_read(a));
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        forever begin
            bus_addr = 12'h008; #2;
            if (!bus_rdata[24]) break;
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic arr_lit(string req, int w, logic [31:0] exp);
        hold = 1;
        @(negedge clk); arr_addr = AW'(w); #3;
        chk(req, arr_rdata, exp);
        hold = 0;
    endtask

    task automatic finish_run;
        done_run = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd("R1 ctrl", 12'h008); chk("R1 ctrl literal", bus_rdata, 0);
        rd("R1 status", 12'h024); rd("R1 prot", 12'h304);
        arr_lit("R1 erased word", 77, 32'hFFFF_FFFF);
        // R12 register map
        bw(12'h004, 32'h0000_0123); rd("R12 divider", 12'h004); chk("R12 div literal", bus_rdata, 32'h123);
        bw(12'h03C, 32'hDEAD_BEEF); rd("R12 data3", 12'h03C);
        bus_addr = 12'h100; #2; chk("R12 unmapped", bus_rdata, 0);
        // R7 32-bit program, R5 pending length
        bw(12'h000, 32'h20); bw(12'h030, 32'hA5A5_0F0F);
        bw(12'h008, 32'h2000_0011); wait_idle(n); chk("R5 write pending", n, WRC);
        rd("R5 after write", 12'h008); chk("R5 ctrl literal", bus_rdata, 32'h2000_0010);
        bw(12'h030, 32'hFFFF_00FF); bw(12'h008, 32'h2000_0011); wait_idle(n);
        arr_lit("R7 AND program", 8, 32'hA5A5_000F);
        // R7 128-bit program
        bw(12'h000, 32'h40);
        for (int k = 0; k < 4; k++) bw(12'h030 + 12'(4 * k), 32'h1111_0000 * (k + 1));
        bw(12'h008, 32'h2800_0001); wait_idle(n);
        arr_lit("R7 wide word2", 18, 32'h3333_0000);
        // R7 misaligned wide, R11 clear
        bw(12'h000, 32'h44); bw(12'h008, 32'h2800_0001);
        rd("R7 misaligned", 12'h024); chk("R7 fail literal", bus_rdata, 2);
        bw(12'h024, 0); rd("R11 clear", 12'h024); chk("R11 cleared", bus_rdata, 0);
        bw(12'h000, 32'h50); bw(12'h008, 32'h2800_0011); rd("R7 both modes", 12'h024);
        bw(12'h024, 2); rd("R11 set by write", 12'h024); bw(12'h024, 0);
        // R2 wrong key
        bw(12'h008, 32'h0000_0011); rd("R2 wrong key", 12'h024); chk("R2 no pending", bus_rdata, 2);
        rd("R2 ctrl", 12'h008); bw(12'h024, 0);
        // R3 qualifier mismatch
        bw(12'h000, 32'h24);
        bw(12'h008, 32'h2000_AA04); rd("R3 page wrong qual", 12'h024); bw(12'h024, 0);
        bw(12'h008, 32'h2000_5511); rd("R3 prog wrong qual", 12'h024); bw(12'h024, 0);
        // R4 two start bits
        bw(12'h008, 32'h2000_5505); rd("R4 two starts", 12'h024); bw(12'h024, 0);
        // R8 page erase of page 2
        bw(12'h008, 32'h2000_5504); wait_idle(n); chk("R5 page erase pending", n, PEC);
        arr_lit("R8 erased", 8, 32'hFFFF_FFFF); arr_lit("R8 other page", 17, 32'h2222_0000);
        bw(12'h000, 32'h1000); bw(12'h008, 32'h2000_5504); rd("R8 out of range", 12'h024); bw(12'h024, 0);
        // R6 busy behaviour
        bw(12'h000, 32'h40); bw(12'h008, 32'h2000_5504);
        bw(12'h008, 32'h2000_0011); bw(12'h000, 32'h80);
        rd("R6 busy refuse", 12'h024); chk("R6 fail literal", bus_rdata, 2);
        rd("R6 addr frozen", 12'h000); chk("R6 addr literal", bus_rdata, 32'h40);
        wait_idle(n); bw(12'h024, 0);
        // program page 5 and page 33 before protecting
        bw(12'h030, 32'h0000_FFFF);
        bw(12'h000, 32'h50); bw(12'h008, 32'h2000_0011); wait_idle(n);
        bw(12'h000, 32'h210); bw(12'h008, 32'h2000_0011); wait_idle(n);
        // R10 protection of page 33 (word 1 bit 1)
        bw(12'h304, 32'h2); bw(12'h030, 0); bw(12'h008, 32'h2000_0011);
        rd("R10 prog protected", 12'h024); bw(12'h024, 0);
        bw(12'h008, 32'h2000_5504); rd("R10 erase protected", 12'h024); bw(12'h024, 0);
        arr_lit("R10 untouched", 132, 32'h0000_FFFF);
        // R9 mass erase skips protected page
        bw(12'h008, 32'h2000_AA02); wait_idle(n); chk("R5 mass pending", n, MEC);
        arr_lit("R9 erased page", 20, 32'hFFFF_FFFF); arr_lit("R9 kept page", 132, 32'h0000_FFFF);
        bw(12'h300, 32'hFFFF_FFFF); bw(12'h304, 32'hFF); bw(12'h008, 32'h2000_AA02);
        rd("R9 all protected", 12'h024); chk("R9 fail literal", bus_rdata, 2);
        repeat (WORDS + 4) @(negedge clk);
        finish_run();
    end
endmodule